// File: doc/BRIEF.md
# SPI Serial SRAM Slave

This block is the slave side of a serial memory port. An external SPI master selects it by pulling `cs_n` low and sends a command byte. Depending on the command, a two-byte address and a stream of data bytes follow, or a single status byte. Data bytes go into, or come out of, a byte-wide register array that holds 2**AW bytes. AW is 15 in the full-size build (32768 bytes). The default is smaller, to keep elaboration light.

All SPI pins are sampled by the block's own clock `clk` through two-stage synchronizers, and SCK edges are found from the sampled copy. Each SCK phase, high or low, must therefore last at least four `clk` periods. A status register holds three things: a write-enable latch, a two-bit write-protect range and a rollover select. The rollover select decides whether a streamed address wraps within a 64-byte page or within a quarter-array block. A `hold_n` input freezes a transfer in mid-stream. A `wp_n` input locks the status register against change.

Top module: `spi_sram_slave`

## Requirements
- R1: SPI modes 0 and 3 are both accepted. SI is taken on each rising SCK edge, and SO moves on each falling SCK edge. Every byte travels most significant bit first.
- R2: The two address bytes form a 16-bit value, high byte first. Only its low AW bits select the array byte, and the bits above them are ignored.
- R3: The first byte after `cs_n` falls is the command: 0x06 set write enable, 0x04 clear write enable, 0x05 read status, 0x01 write status, 0x03 read, 0x02 write. A read returns the byte at the address, then the following bytes, for as long as SCK runs.
- R4: During a write, each complete eighth data bit stores one byte and advances the address. The byte is stored only while the write-enable latch is set.
- R5: Command 0x06 sets the write-enable latch and command 0x04 clears it. A write (0x02) or write-status (0x01) transfer clears the latch when `cs_n` rises.
- R6: The status byte reads as bit 1 = write-enable latch, bits 3:2 = protect range, bit 5 = rollover select, and all other bits zero. It is 0x00 after reset. It repeats for every byte clocked out in one read-status transfer.
- R7: Write-status loads bits 3:2 and bit 5 from its data byte, but only when the write-enable latch is set and `wp_n` is high. Otherwise the status is unchanged.
- R8: Protect range 00 guards nothing, 01 the top quarter, 10 the top half, and 11 the whole array. A write to a guarded byte is dropped without any other effect.
- R9: With rollover select 0, the streamed address wraps from the last byte of its 64-byte page to the first byte of the same page.
- R10: With rollover select 1, the streamed address wraps within its block of 2**(AW-2) bytes and crosses page boundaries freely.
- R11: After an unknown command byte, all further SCK activity is ignored and `so_oe` stays low until `cs_n` is raised. The next selection works normally.
- R12: While `hold_n` is low, SCK edges have no effect and `so_oe` is low. The transfer continues from the same bit once `hold_n` returns high.
- R13: `so_oe` is high only while a read or read-status transfer is shifting data out. It is low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data into the block |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |
| hold_n | input | 1 | Pause input, active low |
| wp_n | input | 1 | Status write lock, active low |

## Verification
The hardest state to reach from the ports is a pause that falls in the middle of a stream, while the master keeps toggling SCK. The stimulus drops `hold_n` between two data bytes of a write, and again between two bytes of a read. It pulses SCK three times during each pause and then restores `hold_n` with SCK at its pre-pause level. After that, both the stored bytes and the read stream must show that none of the extra edges was counted. Wrap behaviour needs a status change first. The stimulus sets the rollover bit and protect fields through write-status, then streams across page and block ends and reads the wrapped bytes back.

// File: rtl/spi_sram_pkg.sv
`timescale 1ns/1ps
package spi_sram_pkg;

  localparam logic [7:0] CMD_WEN_SET  = 8'h06;
  localparam logic [7:0] CMD_WEN_CLR  = 8'h04;
  localparam logic [7:0] CMD_STAT_RD  = 8'h05;
  localparam logic [7:0] CMD_STAT_WR  = 8'h01;
  localparam logic [7:0] CMD_MEM_RD   = 8'h03;
  localparam logic [7:0] CMD_MEM_WR   = 8'h02;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_SDATA,
    PH_DRAIN,
    PH_FROZEN
  } phase_e;

endpackage

// File: rtl/spi_sram_sync.sv
`timescale 1ns/1ps
module spi_sram_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= RST_VAL;
        else        stg_q[0] <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= {stg_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/spi_sram_addr.sv
`timescale 1ns/1ps
module spi_sram_addr #(
  parameter int AW      = 11,
  parameter int PAGE_AW = 6
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    guard,
  input  logic          blk_wrap,
  output logic          guarded,
  output logic [AW-1:0] addr_nxt
);

  localparam int BLK_AW = AW - 2;

  logic [PAGE_AW-1:0] page_inc;
  logic [BLK_AW-1:0]  blk_inc;

  always_comb begin
    unique case (guard)
      2'b00:   guarded = 1'b0;
      2'b01:   guarded = (addr[AW-1:AW-2] == 2'b11);
      2'b10:   guarded = addr[AW-1];
      default: guarded = 1'b1;
    endcase
  end

  assign page_inc = addr[PAGE_AW-1:0] + 1'b1;
  assign blk_inc  = addr[BLK_AW-1:0] + 1'b1;

  always_comb begin
    if (blk_wrap) addr_nxt = {addr[AW-1:BLK_AW], blk_inc};
    else          addr_nxt = {addr[AW-1:PAGE_AW], page_inc};
  end

endmodule

// File: rtl/spi_sram_array.sv
`timescale 1ns/1ps
module spi_sram_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/spi_sram_ctrl.sv
`timescale 1ns/1ps
module spi_sram_ctrl
  import spi_sram_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s_n,
  input  logic          sck_s,
  input  logic          si_s,
  input  logic          hold_s,
  input  logic          wp_s,
  input  logic [7:0]    mem_rdata,
  input  logic          guarded,
  input  logic [AW-1:0] addr_nxt,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          so,
  output logic          so_oe,
  output logic          wen,
  output logic [1:0]    guard,
  output logic          blk_wrap,
  output logic          streaming
);

  phase_e        ph_q, ph_d;
  logic [2:0]    ibit_q, ibit_d;
  logic [6:0]    sin_q, sin_d;
  logic          ahi_seen_q, ahi_seen_d;
  logic [7:0]    ahi_q, ahi_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [7:0]    cmd_q, cmd_d;
  logic          wen_q, wen_d;
  logic [1:0]    guard_q, guard_d;
  logic          bwrap_q, bwrap_d;
  logic          wen_drop_q, wen_drop_d;
  logic [7:0]    sout_q, sout_d;
  logic [2:0]    obit_q, obit_d;
  logic          oval_q, oval_d;
  logic          sck_d1_q;

  logic          sck_rise, sck_fall;
  logic [7:0]    byte_in;
  logic [7:0]    stat_byte;

  assign sck_rise  = hold_s &  sck_s & ~sck_d1_q;
  assign sck_fall  = hold_s & ~sck_s &  sck_d1_q;
  assign byte_in   = {sin_q, si_s};
  assign stat_byte = {2'b00, bwrap_q, 1'b0, guard_q, wen_q, 1'b0};

  always_comb begin
    ph_d       = ph_q;
    ibit_d     = ibit_q;
    sin_d      = sin_q;
    ahi_seen_d = ahi_seen_q;
    ahi_d      = ahi_q;
    addr_d     = addr_q;
    cmd_d      = cmd_q;
    wen_d      = wen_q;
    guard_d    = guard_q;
    bwrap_d    = bwrap_q;
    wen_drop_d = wen_drop_q;
    sout_d     = sout_q;
    obit_d     = obit_q;
    oval_d     = oval_q;
    mem_we     = 1'b0;
    mem_wdata  = byte_in;

    if (cs_s_n) begin
      ph_d       = PH_IDLE;
      ibit_d     = '0;
      obit_d     = '0;
      oval_d     = 1'b0;
      ahi_seen_d = 1'b0;
      if (wen_drop_q) begin
        wen_d      = 1'b0;
        wen_drop_d = 1'b0;
      end
    end else if (ph_q == PH_IDLE) begin
      ph_d = PH_CMD;
    end else begin
      if (sck_rise && (ph_q == PH_CMD || ph_q == PH_ADDR ||
                       ph_q == PH_WDATA || ph_q == PH_SDATA)) begin
        sin_d  = byte_in[6:0];
        ibit_d = ibit_q + 3'd1;
        if (ibit_q == 3'd7) begin
          unique case (ph_q)
            PH_CMD: begin
              cmd_d = byte_in;
              unique case (byte_in)
                CMD_WEN_SET: begin wen_d = 1'b1; ph_d = PH_DRAIN; end
                CMD_WEN_CLR: begin wen_d = 1'b0; ph_d = PH_DRAIN; end
                CMD_STAT_RD: ph_d = PH_RDATA;
                CMD_MEM_RD:  ph_d = PH_ADDR;
                CMD_MEM_WR:  begin ph_d = PH_ADDR;  wen_drop_d = 1'b1; end
                CMD_STAT_WR: begin ph_d = PH_SDATA; wen_drop_d = 1'b1; end
                default:     ph_d = PH_FROZEN;
              endcase
            end
            PH_ADDR: begin
              if (!ahi_seen_q) begin
                ahi_d      = byte_in;
                ahi_seen_d = 1'b1;
              end else begin
                addr_d = AW'({ahi_q, byte_in});
                ph_d   = (cmd_q == CMD_MEM_RD) ? PH_RDATA : PH_WDATA;
              end
            end
            PH_WDATA: begin
              mem_we = wen_q & ~guarded;
              addr_d = addr_nxt;
            end
            default: begin
              if (wen_q && wp_s) begin
                guard_d = byte_in[3:2];
                bwrap_d = byte_in[5];
              end
              ph_d = PH_DRAIN;
            end
          endcase
        end
      end

      if (sck_fall && ph_q == PH_RDATA) begin
        if (obit_q == 3'd0) begin
          if (cmd_q == CMD_STAT_RD) begin
            sout_d = stat_byte;
          end else begin
            sout_d = mem_rdata;
            addr_d = addr_nxt;
          end
        end else begin
          sout_d = {sout_q[6:0], 1'b0};
        end
        obit_d = obit_q + 3'd1;
        oval_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      ibit_q     <= '0;
      sin_q      <= '0;
      ahi_seen_q <= 1'b0;
      ahi_q      <= '0;
      addr_q     <= '0;
      cmd_q      <= '0;
      wen_q      <= 1'b0;
      guard_q    <= '0;
      bwrap_q    <= 1'b0;
      wen_drop_q <= 1'b0;
      sout_q     <= '0;
      obit_q     <= '0;
      oval_q     <= 1'b0;
      sck_d1_q   <= 1'b0;
    end else begin
      ph_q       <= ph_d;
      ibit_q     <= ibit_d;
      sin_q      <= sin_d;
      ahi_seen_q <= ahi_seen_d;
      ahi_q      <= ahi_d;
      addr_q     <= addr_d;
      cmd_q      <= cmd_d;
      wen_q      <= wen_d;
      guard_q    <= guard_d;
      bwrap_q    <= bwrap_d;
      wen_drop_q <= wen_drop_d;
      sout_q     <= sout_d;
      obit_q     <= obit_d;
      oval_q     <= oval_d;
      sck_d1_q   <= sck_s;
    end
  end

  assign mem_addr  = addr_q;
  assign so        = sout_q[7];
  assign so_oe     = oval_q & ~cs_s_n & hold_s & (ph_q == PH_RDATA);
  assign wen       = wen_q;
  assign guard     = guard_q;
  assign blk_wrap  = bwrap_q;
  assign streaming = (ph_q == PH_WDATA) || (ph_q == PH_RDATA);

endmodule

// File: rtl/spi_sram_slave.sv
`timescale 1ns/1ps
module spi_sram_slave #(
  parameter int AW      = 11,
  parameter int PAGE_AW = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_oe,
  input  logic hold_n,
  input  logic wp_n
);

  localparam int PIN_W = 5;

  logic             rst_s_n;
  logic [PIN_W-1:0] pins_s;
  logic             cs_s_n, sck_s, si_s, hold_s, wp_s;
  logic             mem_we, guarded, wen, blk_wrap, streaming;
  logic [AW-1:0]    mem_addr, addr_nxt;
  logic [7:0]       mem_wdata, mem_rdata;
  logic [1:0]       guard;

  spi_sram_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_s_n)
  );

  spi_sram_sync #(.W(PIN_W), .STAGES(2), .RST_VAL(5'b10011)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d     ({cs_n, sck, si, hold_n, wp_n}),
    .q     (pins_s)
  );

  assign {cs_s_n, sck_s, si_s, hold_s, wp_s} = pins_s;

  spi_sram_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .cs_s_n    (cs_s_n),
    .sck_s     (sck_s),
    .si_s      (si_s),
    .hold_s    (hold_s),
    .wp_s      (wp_s),
    .mem_rdata (mem_rdata),
    .guarded   (guarded),
    .addr_nxt  (addr_nxt),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .so        (so),
    .so_oe     (so_oe),
    .wen       (wen),
    .guard     (guard),
    .blk_wrap  (blk_wrap),
    .streaming (streaming)
  );

  spi_sram_addr #(.AW(AW), .PAGE_AW(PAGE_AW)) u_addr (
    .addr     (mem_addr),
    .guard    (guard),
    .blk_wrap (blk_wrap),
    .guarded  (guarded),
    .addr_nxt (addr_nxt)
  );

  spi_sram_array #(.AW(AW), .DW(8)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

endmodule

// File: rtl/spi_sram_slave_chk.sv
`timescale 1ns/1ps
module spi_sram_slave_chk #(
  parameter int AW      = 11,
  parameter int PAGE_AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_s_n,
  input logic          hold_s,
  input logic          wp_s,
  input logic          so_oe,
  input logic          mem_we,
  input logic          guarded,
  input logic          wen,
  input logic [1:0]    guard,
  input logic          blk_wrap,
  input logic          streaming,
  input logic [AW-1:0] addr
);

  p_oe_selected_r13: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> !cs_s_n);

  p_oe_quiet_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_s |-> !so_oe);

  p_store_needs_wen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wen);

  p_store_unguarded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !guarded);

  p_status_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(guard) || !$stable(blk_wrap)) |-> ($past(wen) && $past(wp_s)));

  p_page_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (streaming && $past(streaming) && !blk_wrap)
      |-> (addr[AW-1:PAGE_AW] == $past(addr[AW-1:PAGE_AW])));

endmodule

bind spi_sram_slave spi_sram_slave_chk #(.AW(AW), .PAGE_AW(PAGE_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .cs_s_n    (cs_s_n),
  .hold_s    (hold_s),
  .wp_s      (wp_s),
  .so_oe     (so_oe),
  .mem_we    (mem_we),
  .guarded   (guarded),
  .wen       (wen),
  .guard     (guard),
  .blk_wrap  (blk_wrap),
  .streaming (streaming),
  .addr      (mem_addr)
);

// File: tb/spi_sram_slave_bench.sv
`timescale 1ns/1ps
module spi_sram_slave_bench;

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, si, hold_n, wp_n;
  logic so, so_oe;

  always #2.5 clk = ~clk;

  spi_sram_slave #(.AW(11), .PAGE_AW(6)) u_spi_sram_slave (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .sck    (sck),
    .si     (si),
    .so     (so),
    .so_oe  (so_oe),
    .hold_n (hold_n),
    .wp_n   (wp_n)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int oe_cnt = 0;
  bit mon_en = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  logic [7:0] acc = '0;
  int         nbit = 0;
  bit         oe_bad = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (so_oe === 1'b1) oe_cnt++;

  // monitor: collect each byte shifted out and compare with the scoreboard
  always @(posedge sck) begin
    if (mon_en) begin
      acc = {acc[6:0], so};
      if (so_oe !== 1'b1) oe_bad = 1'b1;
      nbit++;
      if (nbit == 8) begin
        nbit = 0;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected byte", {24'd0, acc}, 32'd0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk((acc === e) && !oe_bad, t, {24'd0, acc}, {24'd0, e});
        end
        oe_bad = 1'b0;
      end
    end
  end

  task automatic hp();
    repeat (4) @(negedge clk);
  endtask

  task automatic sel(input bit m3);
    sck = m3;
    hp();
    cs_n = 1'b0;
    hp();
  endtask

  task automatic desel(input bit m3);
    if (!m3) begin
      sck = 1'b0;
      hp();
    end
    cs_n = 1'b1;
    hp();
    hp();
  endtask

  task automatic tx_bit(input logic b);
    sck = 1'b0;
    si  = b;
    hp();
    sck = 1'b1;
    hp();
  endtask

  task automatic tx_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) tx_bit(v[i]);
  endtask

  task automatic cmd(input logic [7:0] op, input bit m3);
    sel(m3);
    tx_byte(op);
    desel(m3);
  endtask

  task automatic wr(input bit m3, input logic [15:0] a, input int n, input logic [31:0] d);
    sel(m3);
    tx_byte(8'h02);
    tx_byte(a[15:8]);
    tx_byte(a[7:0]);
    for (int k = 0; k < n; k++) tx_byte(d[31-8*k -: 8]);
    desel(m3);
  endtask

  task automatic rd(input bit m3, input logic [15:0] a, input int n, input logic [31:0] d, input string tag);
    sel(m3);
    tx_byte(8'h03);
    tx_byte(a[15:8]);
    tx_byte(a[7:0]);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(d[31-8*k -: 8]);
      tag_q.push_back(tag);
    end
    mon_en = 1'b1;
    for (int k = 0; k < n; k++) tx_byte(8'h00);
    mon_en = 1'b0;
    desel(m3);
  endtask

  task automatic rdsr(input bit m3, input int n, input logic [7:0] e, input string tag);
    sel(m3);
    tx_byte(8'h05);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    mon_en = 1'b1;
    for (int k = 0; k < n; k++) tx_byte(8'h00);
    mon_en = 1'b0;
    desel(m3);
  endtask

  task automatic wrsr(input bit m3, input logic [7:0] v);
    sel(m3);
    tx_byte(8'h01);
    tx_byte(v);
    desel(m3);
  endtask

  task automatic pause(input bit in_read);
    hp();
    hold_n = 1'b0;
    hp();
    hp();
    chk(so_oe == 1'b0, "R12 oe during pause", {31'd0, so_oe}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      sck = 1'b0;
      hp();
      sck = 1'b1;
      hp();
    end
    chk(so_oe == 1'b0, "R12 oe after toggles", {31'd0, so_oe}, 32'd0);
    hold_n = 1'b1;
    hp();
    hp();
    if (in_read) chk(so_oe == 1'b1, "R12 oe resumed", {31'd0, so_oe}, 32'd1);
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    chk(1'b0, "ALL watchdog", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int c0;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; hold_n = 1'b1; wp_n = 1'b1;
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // reset state
    chk(so_oe == 1'b0, "R13 reset oe", {31'd0, so_oe}, 32'd0);
    rdsr(0, 1, 8'h00, "R6 reset status");

    // write-enable latch set and clear
    cmd(8'h06, 0);
    rdsr(1, 1, 8'h02, "R5 latch set");
    cmd(8'h04, 1);
    rdsr(0, 1, 8'h00, "R5 latch cleared");

    // write needs the latch; latch drops at end of write
    cmd(8'h06, 0);
    c0 = oe_cnt;
    wr(0, 16'h0010, 1, 32'h11000000);
    chk(oe_cnt == c0, "R13 no oe in write", oe_cnt - c0, 32'd0);
    rdsr(0, 1, 8'h00, "R5 latch after write");
    wr(0, 16'h0010, 1, 32'h99000000);
    rd(0, 16'h0010, 1, 32'h11000000, "R4 unlatched write dropped");

    // streaming in both modes
    cmd(8'h06, 1);
    wr(1, 16'h0100, 4, 32'hDEADBEEF);
    rd(0, 16'h0100, 4, 32'hDEADBEEF, "R1 R3 mode0 stream");
    rd(1, 16'h0102, 2, 32'hBEEF0000, "R1 mode3 stream");

    // high address bits ignored
    cmd(8'h06, 0);
    wr(0, 16'hF812, 1, 32'h5A000000);
    rd(0, 16'h0012, 1, 32'h5A000000, "R2 upper bits ignored");

    // page rollover
    cmd(8'h06, 0);
    wr(0, 16'h003E, 4, 32'hA0A1A2A3);
    rd(0, 16'h0000, 2, 32'hA2A30000, "R9 write page wrap");
    rd(1, 16'h003F, 2, 32'hA1A20000, "R9 read page wrap");

    // block rollover
    cmd(8'h06, 0);
    wrsr(0, 8'h20);
    rdsr(0, 1, 8'h20, "R7 status write");
    cmd(8'h06, 0);
    wr(0, 16'h007F, 2, 32'hC0C10000);
    rd(0, 16'h0080, 1, 32'hC1000000, "R10 crosses page");
    cmd(8'h06, 1);
    wr(1, 16'h01FF, 2, 32'hB0B10000);
    rd(0, 16'h0000, 1, 32'hB1000000, "R10 block wrap write");
    rd(0, 16'h01FF, 2, 32'hB0B10000, "R10 block wrap read");
    cmd(8'h06, 0);
    wrsr(0, 8'h00);
    rdsr(0, 2, 8'h00, "R6 status repeats");

    // protection ranges
    cmd(8'h06, 0); wr(0, 16'h0600, 1, 32'h33000000);
    cmd(8'h06, 0); wr(0, 16'h0400, 1, 32'h44000000);
    cmd(8'h06, 0); wrsr(0, 8'h04);
    rdsr(0, 1, 8'h04, "R6 protect field");
    cmd(8'h06, 0); wr(0, 16'h0600, 1, 32'h55000000);
    rd(0, 16'h0600, 1, 32'h33000000, "R8 top quarter guarded");
    cmd(8'h06, 0); wr(0, 16'h05FF, 1, 32'h66000000);
    rd(0, 16'h05FF, 1, 32'h66000000, "R8 below quarter open");
    cmd(8'h06, 0); wrsr(0, 8'h08);
    cmd(8'h06, 0); wr(0, 16'h0400, 1, 32'h77000000);
    rd(0, 16'h0400, 1, 32'h44000000, "R8 top half guarded");
    cmd(8'h06, 0); wr(0, 16'h03FF, 1, 32'h12000000);
    rd(0, 16'h03FF, 1, 32'h12000000, "R8 lower half open");
    cmd(8'h06, 0); wrsr(0, 8'h0C);
    cmd(8'h06, 0); wr(0, 16'h0010, 1, 32'hEE000000);
    rd(0, 16'h0010, 1, 32'h11000000, "R8 whole array guarded");

    // status lock pin and latch
    wp_n = 1'b0;
    cmd(8'h06, 0); wrsr(0, 8'h00);
    rdsr(0, 1, 8'h0C, "R7 pin locks status");
    wp_n = 1'b1;
    wrsr(0, 8'h00);
    rdsr(0, 1, 8'h0C, "R7 latch needed");
    cmd(8'h06, 0); wrsr(0, 8'h00);
    rdsr(0, 1, 8'h00, "R7 status cleared");

    // unknown command freezes the transfer
    c0 = oe_cnt;
    sel(0);
    tx_byte(8'hAB);
    tx_byte(8'h06);
    tx_byte(8'h03);
    tx_byte(8'h00);
    tx_byte(8'h10);
    tx_byte(8'h00);
    chk(oe_cnt == c0, "R11 oe stays low", oe_cnt - c0, 32'd0);
    desel(0);
    rdsr(0, 1, 8'h00, "R11 later bytes ignored");

    // pause in a write and in a read
    cmd(8'h06, 0);
    sel(0);
    tx_byte(8'h02); tx_byte(8'h02); tx_byte(8'h00);
    tx_byte(8'h91);
    pause(0);
    tx_byte(8'h92);
    desel(0);
    rd(0, 16'h0200, 2, 32'h91920000, "R12 write across pause");

    sel(1);
    tx_byte(8'h03); tx_byte(8'h02); tx_byte(8'h00);
    exp_q.push_back(8'h91); tag_q.push_back("R12 read before pause");
    exp_q.push_back(8'h92); tag_q.push_back("R12 read after pause");
    mon_en = 1'b1;
    tx_byte(8'h00);
    mon_en = 1'b0;
    pause(1);
    mon_en = 1'b1;
    tx_byte(8'h00);
    mon_en = 1'b0;
    desel(1);

    chk(exp_q.size() == 0, "R3 all bytes seen", exp_q.size(), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule